// File: doc/BRIEF.md
# SPI Register-Access Slave

This block lets an external serial master read and write a small bank of 8-bit registers over an SPI link. Every transfer opens with a one-byte command that holds a direction flag, an auto-increment flag and a 6-bit register address. Data bytes follow, and a transfer may carry any number of them in a burst. A constant identification register is built in. Three configuration registers drive the rest of the chip through output ports. A status byte and a 16-bit measurement sample come in on input ports and can be read but not written.

All logic runs on the system clock `clk`. The serial pins pass through a synchronizer of `SYNC_STAGES` flops before edge detection. The serial clock idles high. The slave samples input bits on serial-clock rising edges and updates read data after falling edges. Bit 0 of the control register chooses the data wiring. When it is 0, read data goes out on a separate output pin. When it is 1, the data-input pin is turned around and the slave drives read data on it.

Top module: `spi_regslave`

## Requirements
- R1: The first 8 rising serial-clock edges after `cs_n` falls carry the command, most significant bit first. Command bit 7 is the direction (1 = read), bit 6 is the increment flag, and bits 5..0 are the register address.
- R2: In a read, each data bit is presented after a falling serial-clock edge and is valid before the next rising edge, most significant bit first. A single-byte read takes 16 rising edges.
- R3: In a write, 8 data bits are sampled on rising edges, most significant bit first. The register is updated only when the eighth data bit of a byte has been received. Registers never change while `cs_n` is high.
- R4: If the increment flag is 1, the register address advances by one (modulo 64) after each data byte of a burst. If it is 0, every byte of the burst uses the same address.
- R5: Address 0x0F always reads 0xD1. Writes to it have no effect.
- R6: Addresses 0x20, 0x22 and 0x23 are read/write and drive `ctrl_o`, `filt_o` and `osel_o`. Address 0x27 reads `status_in`, 0x28 reads `sample_in[15:8]` and 0x29 reads `sample_in[7:0]`. Writes to those three read-only addresses have no effect.
- R7: Every other address reads 0x00. A write to one changes no register.
- R8: Raising `cs_n` at any point ends the transfer. A partly shifted write byte is discarded, both output enables are low within `SYNC_STAGES+2` clock cycles, and the next transfer starts again with a command byte.
- R9: When `ctrl_o[0]` is 1, read data appears on `dio_out` with `dio_oe` high, and `sdo_oe` stays low. Multi-byte reads work the same way in this mode.
- R10: When `ctrl_o[0]` is 0, read data appears on `sdo`, and `sdo_oe` is high only during the data phase of a read. `dio_oe` stays low.
- R11: After reset, `ctrl_o`, `filt_o` and `osel_o` are 0x00 and both output enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the master, idles high |
| sdi | input | 1 | Serial data in; also the turned-around data pin in 3-wire mode |
| sdo | output | 1 | Serial read data, 4-wire mode |
| sdo_oe | output | 1 | Output enable for `sdo` |
| dio_out | output | 1 | Read data to drive onto the data-input pin, 3-wire mode |
| dio_oe | output | 1 | Output enable for the data-input pin |
| sample_in | input | 16 | Measurement sample, readable as two bytes |
| status_in | input | 8 | Status byte, readable |
| ctrl_o | output | 8 | Control register; bit 0 selects 3-wire mode |
| filt_o | output | 8 | Filter configuration register |
| osel_o | output | 8 | Output select register |

## Verification
A serial-clock edge reaches the design `SYNC_STAGES` cycles after the pin changes. The edge is detected one cycle later, and the output flop updates in the cycle after that. A read bit is therefore due about `SYNC_STAGES+2` clocks after the falling edge, and a register write lands the same number of clocks after the eighth data rising edge. The bench holds each serial-clock phase for 8 system clocks and samples read data and enables in the last clock of the low phase, which is well after the bit is due. Register outputs and idle enables are compared with the model on every clock, but only once `cs_n` has been high for 16 clocks. Abort release is checked 6 clocks after `cs_n` rises.

// File: rtl/spi_regslave_pkg.sv
package spi_regslave_pkg;
   localparam int ADDR_W = 6;
   localparam int DATA_W = 8;

   typedef logic [ADDR_W-1:0] reg_addr_t;
   typedef logic [DATA_W-1:0] byte_t;

   localparam reg_addr_t A_ID   = 6'h0F;
   localparam reg_addr_t A_CTRL = 6'h20;
   localparam reg_addr_t A_FILT = 6'h22;
   localparam reg_addr_t A_OSEL = 6'h23;
   localparam reg_addr_t A_STAT = 6'h27;
   localparam reg_addr_t A_OUTH = 6'h28;
   localparam reg_addr_t A_OUTL = 6'h29;

   typedef enum logic {PH_CMD, PH_DATA} phase_e;

   typedef struct packed {
      logic      rd;
      logic      inc;
      reg_addr_t addr;
   } cmd_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 1) begin : g_bad_stages
      $error("spi_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_single
      logic q_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q_r <= RST_VAL;
         else        q_r <= d;
      end
      assign q = q_r;
   end else begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{RST_VAL}};
         else        chain <= {chain[STAGES-2:0], d};
      end
      assign q = chain[STAGES-1];
   end
endmodule

// File: rtl/spi_frame.sv
module spi_frame
   import spi_regslave_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      cs_s,
   input  logic      sclk_s,
   input  logic      sdi_s,
   input  byte_t     rd_data,
   output reg_addr_t rd_addr,
   output logic      wr_en,
   output reg_addr_t wr_addr,
   output byte_t     wr_data,
   output logic      tx_bit,
   output logic      drive
);
   localparam int CNT_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

   logic             sclk_d;
   logic             rise, fall;
   logic [CNT_W-1:0] bit_cnt;
   phase_e           phase;
   cmd_t             cmd_q;
   logic [DATA_W-2:0] rx;
   byte_t            tx;
   byte_t            byte_in;
   logic             byte_done;
   reg_addr_t        next_addr;

   assign rise      = ~cs_s &  sclk_s & ~sclk_d;
   assign fall      = ~cs_s & ~sclk_s &  sclk_d;
   assign byte_in   = {rx, sdi_s};
   assign byte_done = rise && (bit_cnt == LAST_BIT);
   assign next_addr = cmd_q.inc ? cmd_q.addr + 1'b1 : cmd_q.addr;

   // Address whose contents are loaded at the next byte boundary
   assign rd_addr = (phase == PH_CMD) ? byte_in[ADDR_W-1:0] : next_addr;

   assign wr_en   = byte_done && (phase == PH_DATA) && !cmd_q.rd;
   assign wr_addr = cmd_q.addr;
   assign wr_data = byte_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_d <= 1'b1;
      else        sclk_d <= sclk_s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt <= '0;
         phase   <= PH_CMD;
         cmd_q   <= '0;
         rx      <= '0;
         tx      <= '0;
         tx_bit  <= 1'b0;
         drive   <= 1'b0;
      end else if (cs_s) begin
         bit_cnt <= '0;
         phase   <= PH_CMD;
         tx_bit  <= 1'b0;
         drive   <= 1'b0;
      end else begin
         if (rise) begin
            rx      <= byte_in[DATA_W-2:0];
            bit_cnt <= bit_cnt + 1'b1;
            if (byte_done) begin
               tx <= rd_data;
               if (phase == PH_CMD) begin
                  cmd_q <= byte_in;
                  phase <= PH_DATA;
               end else begin
                  cmd_q.addr <= next_addr;
               end
            end
         end
         if (fall && (phase == PH_DATA) && cmd_q.rd) begin
            tx_bit <= tx[DATA_W-1];
            tx     <= {tx[DATA_W-2:0], 1'b0};
            drive  <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/spi_regbank.sv
module spi_regbank
   import spi_regslave_pkg::*;
#(
   parameter byte_t ID_VALUE = 8'hD1,
   parameter byte_t CTRL_RST = 8'h00,
   parameter byte_t FILT_RST = 8'h00,
   parameter byte_t OSEL_RST = 8'h00
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  reg_addr_t   wr_addr,
   input  byte_t       wr_data,
   input  reg_addr_t   rd_addr,
   output byte_t       rd_data,
   input  logic [15:0] sample_in,
   input  byte_t       status_in,
   output byte_t       ctrl_o,
   output byte_t       filt_o,
   output byte_t       osel_o
);
   localparam int NRW = 3;
   localparam reg_addr_t [NRW-1:0] RW_ADDR = {A_OSEL, A_FILT, A_CTRL};
   localparam byte_t     [NRW-1:0] RW_RST  = {OSEL_RST, FILT_RST, CTRL_RST};

   byte_t [NRW-1:0] rw_q;

   for (genvar g = 0; g < NRW; g++) begin : g_rw
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                            rw_q[g] <= RW_RST[g];
         else if (wr_en && wr_addr == RW_ADDR[g]) rw_q[g] <= wr_data;
      end
   end

   assign ctrl_o = rw_q[0];
   assign filt_o = rw_q[1];
   assign osel_o = rw_q[2];

   always_comb begin
      unique case (rd_addr)
         A_ID:    rd_data = ID_VALUE;
         A_CTRL:  rd_data = rw_q[0];
         A_FILT:  rd_data = rw_q[1];
         A_OSEL:  rd_data = rw_q[2];
         A_STAT:  rd_data = status_in;
         A_OUTH:  rd_data = sample_in[15:8];
         A_OUTL:  rd_data = sample_in[7:0];
         default: rd_data = '0;
      endcase
   end
endmodule

// File: rtl/spi_regslave.sv
module spi_regslave
   import spi_regslave_pkg::*;
#(
   parameter int    SYNC_STAGES = 2,
   parameter int    MODE_BIT    = 0,
   parameter byte_t ID_VALUE    = 8'hD1,
   parameter byte_t CTRL_RST    = 8'h00,
   parameter byte_t FILT_RST    = 8'h00,
   parameter byte_t OSEL_RST    = 8'h00
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cs_n,
   input  logic        sclk,
   input  logic        sdi,
   output logic        sdo,
   output logic        sdo_oe,
   output logic        dio_out,
   output logic        dio_oe,
   input  logic [15:0] sample_in,
   input  logic [7:0]  status_in,
   output logic [7:0]  ctrl_o,
   output logic [7:0]  filt_o,
   output logic [7:0]  osel_o
);
   if (MODE_BIT < 0 || MODE_BIT >= DATA_W) begin : g_bad_mode_bit
      $error("spi_regslave: MODE_BIT outside the control register");
   end

   logic      cs_s, sclk_s, sdi_s;
   logic      wr_en, tx_bit, drive, three_wire;
   reg_addr_t rd_addr, wr_addr;
   byte_t     rd_data, wr_data;

   spi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
      .clk(clk), .rst_n(rst_n), .d(cs_n), .q(cs_s));
   spi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sclk (
      .clk(clk), .rst_n(rst_n), .d(sclk), .q(sclk_s));
   spi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sdi (
      .clk(clk), .rst_n(rst_n), .d(sdi), .q(sdi_s));

   spi_frame u_frame (
      .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sclk_s(sclk_s), .sdi_s(sdi_s),
      .rd_data(rd_data), .rd_addr(rd_addr),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .tx_bit(tx_bit), .drive(drive));

   spi_regbank #(
      .ID_VALUE(ID_VALUE), .CTRL_RST(CTRL_RST),
      .FILT_RST(FILT_RST), .OSEL_RST(OSEL_RST)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .sample_in(sample_in), .status_in(status_in),
      .ctrl_o(ctrl_o), .filt_o(filt_o), .osel_o(osel_o));

   assign three_wire = ctrl_o[MODE_BIT];
   assign sdo        = tx_bit;
   assign dio_out    = tx_bit;
   assign sdo_oe     = drive & ~three_wire;
   assign dio_oe     = drive &  three_wire;
endmodule

// File: rtl/spi_regslave_chk.sv
module spi_regslave_chk #(
   parameter int SYNC_STAGES = 2,
   parameter int MODE_BIT    = 0
) (
   input logic       clk,
   input logic       rst_n,
   input logic       cs_n,
   input logic       sdo_oe,
   input logic       dio_oe,
   input logic [7:0] ctrl_o,
   input logic [7:0] filt_o,
   input logic [7:0] osel_o
);
   localparam int LIM = SYNC_STAGES + 3;
   localparam int CW  = $clog2(LIM + 1) + 1;

   logic [CW-1:0] idle_cnt;
   logic          settled;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                idle_cnt <= '0;
      else if (!cs_n)            idle_cnt <= '0;
      else if (idle_cnt < CW'(LIM)) idle_cnt <= idle_cnt + 1'b1;
   end
   assign settled = (idle_cnt >= CW'(LIM));

   assert_oe_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(sdo_oe && dio_oe));

   assert_three_wire_sdo_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_o[MODE_BIT] |-> !sdo_oe);

   assert_four_wire_dio_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_o[MODE_BIT] |-> !dio_oe);

   assert_idle_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      settled |-> (!sdo_oe && !dio_oe));

   assert_idle_regs_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      settled |=> $stable({ctrl_o, filt_o, osel_o}));
endmodule

bind spi_regslave spi_regslave_chk #(
   .SYNC_STAGES(SYNC_STAGES), .MODE_BIT(MODE_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdo_oe(sdo_oe), .dio_oe(dio_oe),
   .ctrl_o(ctrl_o), .filt_o(filt_o), .osel_o(osel_o));

// File: tb/tb_spi_regslave.sv
`timescale 1ns/1ps
module tb_spi_regslave;
   localparam int HALF = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1;
   logic sclk = 1'b1;
   logic m_sdi = 1'b0;
   logic m_drive = 1'b1;
   logic sdo, sdo_oe, dio_out, dio_oe;
   logic [15:0] sample_in = 16'hBE3C;
   logic [7:0]  status_in = 8'h5A;
   logic [7:0]  ctrl_o, filt_o, osel_o;
   logic        pin_sdi;

   always #5 clk = ~clk;

   // open-drain style pull-up when nobody drives the shared data pin
   assign pin_sdi = dio_oe ? dio_out : (m_drive ? m_sdi : 1'b1);

   spi_regslave dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(pin_sdi),
      .sdo(sdo), .sdo_oe(sdo_oe), .dio_out(dio_out), .dio_oe(dio_oe),
      .sample_in(sample_in), .status_in(status_in),
      .ctrl_o(ctrl_o), .filt_o(filt_o), .osel_o(osel_o));

   int n_chk = 0;
   int n_err = 0;
   bit chk_idle = 0;
   logic [7:0] m_ctrl = 8'h00, m_filt = 8'h00, m_osel = 8'h00;
   logic [7:0] wq[$];
   logic [7:0] rq[$];

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] model_read(input logic [5:0] a);
      case (a)
         6'h0F:   return 8'hD1;
         6'h20:   return m_ctrl;
         6'h22:   return m_filt;
         6'h23:   return m_osel;
         6'h27:   return status_in;
         6'h28:   return sample_in[15:8];
         6'h29:   return sample_in[7:0];
         default: return 8'h00;
      endcase
   endfunction

   function automatic void model_write(input logic [5:0] a, input logic [7:0] d);
      case (a)
         6'h20:   m_ctrl = d;
         6'h22:   m_filt = d;
         6'h23:   m_osel = d;
         default: ;
      endcase
   endfunction

   // Per-clock comparison of the register outputs while the link is idle
   always @(negedge clk) begin
      if (chk_idle) begin
         chk(ctrl_o == m_ctrl, "R3", "idle ctrl_o", ctrl_o, m_ctrl);
         chk(filt_o == m_filt, "R3", "idle filt_o", filt_o, m_filt);
         chk(osel_o == m_osel, "R3", "idle osel_o", osel_o, m_osel);
         chk(!sdo_oe && !dio_oe, "R8", "idle enables", {sdo_oe, dio_oe}, 0);
      end
   end

   // One transfer; stops after max_rises rising edges (abort when short)
   task automatic xfer(input bit rd, input bit inc, input logic [5:0] addr,
                       input int nbytes, input int max_rises, input string req);
      logic [7:0] cmd;
      logic [7:0] cur, exp_b, got;
      logic [5:0] a;
      bit         three;
      int         total;
      cmd = {rd, inc, addr};
      three = m_ctrl[0];
      total = 8 + 8 * nbytes;
      a = addr;
      cur = 8'h00; exp_b = 8'h00; got = 8'h00;
      rq.delete();
      chk_idle = 0;
      @(negedge clk) cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
      for (int k = 0; k < total && k < max_rises; k++) begin
         int j;
         j = k % 8;
         if (k >= 8 && j == 0) begin
            if (rd) exp_b = model_read(a);
            else    cur = wq.pop_front();
         end
         sclk = 1'b0;
         if (k < 8)      begin m_drive = 1'b1; m_sdi = cmd[7-k]; end
         else if (!rd)   begin m_drive = 1'b1; m_sdi = cur[7-j]; end
         else            begin m_drive = !three; m_sdi = 1'b0; end
         repeat (HALF - 1) @(negedge clk);
         if (k < 8) begin
            chk(!sdo_oe && !dio_oe, "R1", "enables in command phase", {sdo_oe, dio_oe}, 0);
         end else if (rd) begin
            if (three) begin
               chk(dio_oe && !sdo_oe, "R9", "3-wire enables", {sdo_oe, dio_oe}, 1);
               got[7-j] = dio_out;
            end else begin
               chk(sdo_oe && !dio_oe, "R10", "4-wire enables", {sdo_oe, dio_oe}, 2);
               got[7-j] = sdo;
            end
         end
         @(negedge clk) sclk = 1'b1;
         repeat (HALF - 1) @(negedge clk);
         if (k >= 8 && j == 7) begin
            if (rd) begin
               chk(got == exp_b, req, $sformatf("read byte @%0h", a), got, exp_b);
               rq.push_back(got);
            end else begin
               model_write(a, cur);
            end
            if (inc) a = a + 6'd1;   // R4 address step
         end
      end
      @(negedge clk) begin cs_n = 1'b1; m_drive = 1'b1; end
      repeat (6) @(negedge clk);
      chk(!sdo_oe && !dio_oe, "R8", "enables after cs_n high", {sdo_oe, dio_oe}, 0);
      repeat (2 * HALF - 6) @(negedge clk);
      chk_idle = 1;
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      // R11 reset state
      chk(ctrl_o == 8'h00 && filt_o == 8'h00 && osel_o == 8'h00, "R11", "reset regs",
          {ctrl_o, filt_o, osel_o}, 0);
      chk(!sdo_oe && !dio_oe, "R11", "reset enables", {sdo_oe, dio_oe}, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk_idle = 1;

      // R5 R1 R2: single identification read, 16 rising edges
      xfer(1, 0, 6'h0F, 1, 1000, "R5");
      // R3 R6: write filter register then read it back
      wq.push_back(8'hA5);
      xfer(0, 0, 6'h22, 1, 1000, "R3");
      xfer(1, 0, 6'h22, 1, 1000, "R6");
      // R4: incrementing write burst over filter and output select
      wq.push_back(8'h3C); wq.push_back(8'hC3);
      xfer(0, 1, 6'h22, 2, 1000, "R4");
      chk(filt_o == 8'h3C && osel_o == 8'hC3, "R4", "burst write outputs",
          {filt_o, osel_o}, 16'h3CC3);
      // R6 R7: incrementing read burst status, sample high/low, reserved
      xfer(1, 1, 6'h27, 4, 1000, "R6");
      chk(rq.size() == 4 && rq[3] == 8'h00, "R7", "reserved byte in burst",
          rq.size() == 4 ? rq[3] : 8'hFF, 0);
      // R4: non-incrementing read burst repeats identification
      xfer(1, 0, 6'h0F, 3, 1000, "R4");
      chk(rq.size() == 3 && rq[0] == 8'hD1 && rq[2] == 8'hD1, "R4", "fixed-address burst",
          rq.size() == 3 ? rq[2] : 0, 8'hD1);
      // R4: non-incrementing write burst, last byte wins
      wq.push_back(8'h11); wq.push_back(8'h77);
      xfer(0, 0, 6'h23, 2, 1000, "R4");
      chk(osel_o == 8'h77, "R4", "fixed-address write", osel_o, 8'h77);
      // R5 R7 R6: writes to read-only and reserved addresses ignored
      wq.push_back(8'h00); xfer(0, 0, 6'h0F, 1, 1000, "R5");
      xfer(1, 0, 6'h0F, 1, 1000, "R5");
      wq.push_back(8'hFF); xfer(0, 0, 6'h21, 1, 1000, "R7");
      xfer(1, 0, 6'h21, 1, 1000, "R7");
      wq.push_back(8'h99); xfer(0, 0, 6'h28, 1, 1000, "R6");
      xfer(1, 0, 6'h28, 1, 1000, "R6");
      chk(ctrl_o == 8'h00 && filt_o == 8'h3C && osel_o == 8'h77, "R7",
          "rw regs after ignored writes", {ctrl_o, filt_o, osel_o}, 24'h003C77);
      // R8: abort a write after 4 data bits, then a read mid-byte
      wq.push_back(8'hE7);
      xfer(0, 0, 6'h22, 1, 12, "R8");
      wq.delete();
      chk(filt_o == 8'h3C, "R8", "aborted write discarded", filt_o, 8'h3C);
      xfer(1, 1, 6'h28, 2, 13, "R8");
      xfer(1, 0, 6'h22, 1, 1000, "R8");
      // R9: switch to 3-wire, burst read, identification, then back
      wq.push_back(8'h01); xfer(0, 0, 6'h20, 1, 1000, "R9");
      chk(ctrl_o == 8'h01, "R9", "mode bit set", ctrl_o, 8'h01);
      xfer(1, 1, 6'h28, 2, 1000, "R9");
      xfer(1, 0, 6'h0F, 1, 1000, "R9");
      wq.push_back(8'h00); xfer(0, 0, 6'h20, 1, 1000, "R9");
      // R10: 4-wire read again after returning
      xfer(1, 1, 6'h29, 1, 1000, "R10");

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule